// File: doc/BRIEF.md
# Serial Identification Responder

This block answers a host that drives a slow, software-timed serial link by writing a five-bit control word. The word carries a serial clock, a data bit, a start flag, a local reset flag and a command-mode flag. The block watches the serial clock across successive writes and returns one bit through a registered read output.

Two services are offered. In the first, the host raises start and clocks once. This loads a fixed 32-bit board identifier. The host then drops start and clocks repeatedly, and the identifier comes out most significant bit first.

In the second, the host holds command mode high and clocks in an 8-bit command on rising serial-clock edges. It then drops command mode on a falling edge, which executes the command. A command can select one of 64 eight-byte blocks in an internal read-only table. It can also place one byte of the selected block in the top byte of the output register, ready to be shifted out.

Top module: `serial_id_responder`

## Requirements
- R1: A synchronous active-high `rst` clears the control state to idle, the bit position to 0, the output register, the command register, the last-executed command, the block index and `rd_bit`.
- R2: The fields of `wr_data` are placed as follows: bit 0 is serial data, bit 1 is serial clock, bit 2 is the local reset flag, bit 3 is start and bit 4 is command mode. A serial-clock edge is a change of bit 1 relative to its value in the previous strobed write.
- R3: A strobed write with the local reset flag set returns the control state to idle and the bit position to 0. This happens before any edge processing of that same write.
- R4: On a falling serial-clock edge, idle moves to the load state if start is 1, and load moves to the shift state if start is 0. On an edge that leaves the state at load, the output register takes the board identifier (default 0x980055AA) and the position becomes 0.
- R5: On a falling edge that leaves the state at shift, the position advances by one. `rd_bit` shows output register bit (31 − position), one clock after the write that changed it.
- R6: The position saturates at 63. Any position of 32 or more reads as 0.
- R7: On a rising serial-clock edge with command mode 1, serial data enters the least significant bit of the 8-bit command register and the older bits move up.
- R8: A command executes on a falling edge whose write has command mode 0, where the command-mode value last latched was 1. It executes only if the command differs from the last executed one, which then becomes that command. A rising edge with command mode 1, or any falling edge, updates the latched command mode.
- R9: An executed command with bits 7 and 0 both 1 sets the block index to bits 6:1, clears the output register and resets the position, leaving the control state unchanged.
- R10: Executed commands 0x55, 0xAA, 0x54, 0xA8, 0x50, 0xA0, 0x40 and 0x80 select byte 0 to 7, in that order, at table address 8 × index + byte. The table holds ((address × 29) >> 1) mod 256 + 0xA5, mod 256. Such a command loads that byte into output bits 31:24, zeroes the other bits, resets the position and forces the shift state. Command execution overrides the load and advance of the same edge.
- R11: Cycles without a write strobe change neither the state, the position, the output register nor `rd_bit`, whatever `wr_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 5 | Control word: mode, start, local reset, serial clock, serial data |
| rd_bit | output | 1 | Registered returned data bit |

## Verification
The bench reads the whole identifier back and compares the 32 collected bits. A block that advanced the position on the load edge, or numbered bits from the wrong end, would return a rotated or mirrored word. The bench clocks past bit 0 to confirm that the read saturates at zero rather than wrapping to the top bit.

It selects a block, fetches a byte whose top bit is 1, and then repeats the same command. A design that ignored the last-command guard would reload the byte and return 1 where 0 is due.

Random control words, with the local reset and the start flag mixed in, are checked against a bench model on every write. Noise applied with the strobe low must leave the output untouched.

// File: rtl/srid_pkg.sv
package srid_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } srid_state_e;

  // Packed so that the field order matches the write word, bit 4 down to 0
  typedef struct packed {
    logic mode;
    logic start;
    logic lrst;
    logic sclk;
    logic sdat;
  } srid_word_t;

  typedef struct packed {
    logic       go_index;
    logic       go_byte;
    logic [2:0] slot;
  } srid_exec_t;

  // Returns {hit, slot} for the byte-select opcodes
  function automatic logic [3:0] opcode_slot(input logic [7:0] c);
    case (c)
      8'h55:   opcode_slot = 4'b1_000;
      8'hAA:   opcode_slot = 4'b1_001;
      8'h54:   opcode_slot = 4'b1_010;
      8'hA8:   opcode_slot = 4'b1_011;
      8'h50:   opcode_slot = 4'b1_100;
      8'hA0:   opcode_slot = 4'b1_101;
      8'h40:   opcode_slot = 4'b1_110;
      8'h80:   opcode_slot = 4'b1_111;
      default: opcode_slot = 4'b0_000;
    endcase
  endfunction

endpackage

// File: rtl/srid_strobe.sv
module srid_strobe
  import srid_pkg::*;
#(
  parameter int WORD_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output srid_word_t        word,
  output logic              fall,
  output logic              rise,
  output logic              sclk_prev
);

  logic sclk_q;

  assign word      = srid_word_t'(wr_data[4:0]);
  assign fall      = wr_en &  sclk_q & ~word.sclk;
  assign rise      = wr_en & ~sclk_q &  word.sclk;
  assign sclk_prev = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
    end else if (wr_en) begin
      sclk_q <= word.sclk;
    end
  end

endmodule

// File: rtl/srid_cmd.sv
module srid_cmd
  import srid_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall,
  input  logic             rise,
  input  logic             sdat,
  input  logic             mode,
  output srid_exec_t       exec,
  output logic [IDX_W-1:0] idx,
  output logic             mode_prev
);

  logic [CMD_W-1:0] cmd_q;
  logic [CMD_W-1:0] last_q;
  logic [IDX_W-1:0] idx_q;
  logic             mode_q;
  logic             fire;
  logic [3:0]       dec;

  assign fire      = fall & mode_q & ~mode & (cmd_q != last_q);
  assign dec       = opcode_slot(cmd_q[7:0]);
  assign idx       = idx_q;
  assign mode_prev = mode_q;

  always_comb begin
    exec          = '0;
    exec.go_index = fire & cmd_q[7] & cmd_q[0];
    exec.go_byte  = fire & dec[3];
    exec.slot     = dec[2:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      last_q <= '0;
      idx_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (rise && mode) begin
        cmd_q  <= {cmd_q[CMD_W-2:0], sdat};
        mode_q <= 1'b1;
      end
      if (fall) begin
        mode_q <= mode;
      end
      if (fire) begin
        last_q <= cmd_q;
      end
      if (exec.go_index) begin
        idx_q <= cmd_q[IDX_W:1];
      end
    end
  end

endmodule

// File: rtl/srid_rom.sv
module srid_rom #(
  parameter int         BLOCKS = 64,
  parameter int         BLK_SZ = 8,
  parameter logic [7:0] SALT   = 8'hA5,
  localparam int        AW     = $clog2(BLOCKS * BLK_SZ)
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    data
);

  logic [15:0] prod;

  always_comb begin
    prod = 16'(addr) * 16'd29;
    data = prod[8:1] + SALT;
  end

endmodule

// File: rtl/srid_core.sv
module srid_core
  import srid_pkg::*;
#(
  parameter int          OUT_W = 32,
  parameter logic [31:0] ID    = 32'h980055AA,
  localparam int         POS_W = $clog2(OUT_W) + 1,
  localparam int         BIT_W = $clog2(OUT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  srid_word_t       word,
  input  logic             fall,
  input  srid_exec_t       exec,
  input  logic [7:0]       rom_byte,
  output logic             rd_bit,
  output logic [1:0]       st_o,
  output logic [POS_W-1:0] pos_o,
  output logic [OUT_W-1:0] out_o
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  srid_state_e      st_q, st_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic [OUT_W-1:0] out_q, out_n;
  logic             rd_q;
  logic [POS_W-1:0] bsel;
  logic             rd_n;

  always_comb begin
    st_n  = st_q;
    pos_n = pos_q;
    out_n = out_q;
    if (wr_en) begin
      if (word.lrst) begin
        st_n  = ST_IDLE;
        pos_n = '0;
      end
      if (fall) begin
        if (st_n == ST_IDLE && word.start) begin
          st_n = ST_LOAD;
        end else if (st_n == ST_LOAD && !word.start) begin
          st_n = ST_SHIFT;
        end
        if (st_n == ST_LOAD) begin
          out_n = ID[OUT_W-1:0];
          pos_n = '0;
        end else if (st_n == ST_SHIFT && pos_n != POS_MAX) begin
          pos_n = pos_n + 1'b1;
        end
        if (exec.go_index) begin
          out_n = '0;
          pos_n = '0;
        end else if (exec.go_byte) begin
          out_n = {rom_byte, {(OUT_W-8){1'b0}}};
          pos_n = '0;
          st_n  = ST_SHIFT;
        end
      end
    end
  end

  always_comb begin
    bsel = POS_W'(OUT_W - 1) - pos_q;
    rd_n = (pos_q < POS_W'(OUT_W)) ? out_q[bsel[BIT_W-1:0]] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      pos_q <= '0;
      out_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      pos_q <= pos_n;
      out_q <= out_n;
      rd_q  <= rd_n;
    end
  end

  assign rd_bit = rd_q;
  assign st_o   = st_q;
  assign pos_o  = pos_q;
  assign out_o  = out_q;

endmodule

// File: rtl/serial_id_responder.sv
module serial_id_responder
  import srid_pkg::*;
#(
  parameter int          WORD_W = 5,
  parameter int          OUT_W  = 32,
  parameter logic [31:0] ID     = 32'h980055AA,
  parameter int          BLOCKS = 64,
  parameter logic [7:0]  SALT   = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              rd_bit
);

  localparam int BLK_SZ = 8;
  localparam int IDX_W  = $clog2(BLOCKS);
  localparam int AW     = $clog2(BLOCKS * BLK_SZ);
  localparam int POS_W  = $clog2(OUT_W) + 1;

  srid_word_t       word;
  logic             fall, rise, sclk_prev;
  srid_exec_t       exec;
  logic [IDX_W-1:0] idx;
  logic             mode_prev;
  logic [7:0]       rom_byte;
  logic [AW-1:0]    rom_addr;
  logic [1:0]       st;
  logic [POS_W-1:0] pos;
  logic [OUT_W-1:0] shreg;

  srid_strobe #(.WORD_W(WORD_W)) u_strobe (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .word(word), .fall(fall), .rise(rise), .sclk_prev(sclk_prev)
  );

  srid_cmd #(.CMD_W(8), .IDX_W(IDX_W)) u_cmd (
    .clk(clk), .rst(rst), .fall(fall), .rise(rise),
    .sdat(word.sdat), .mode(word.mode),
    .exec(exec), .idx(idx), .mode_prev(mode_prev)
  );

  assign rom_addr = {idx, exec.slot};

  srid_rom #(.BLOCKS(BLOCKS), .BLK_SZ(BLK_SZ), .SALT(SALT)) u_rom (
    .addr(rom_addr), .data(rom_byte)
  );

  srid_core #(.OUT_W(OUT_W), .ID(ID)) u_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .word(word), .fall(fall),
    .exec(exec), .rom_byte(rom_byte), .rd_bit(rd_bit),
    .st_o(st), .pos_o(pos), .out_o(shreg)
  );

endmodule

// File: rtl/srid_checker.sv
module srid_checker #(
  parameter int          OUT_W = 32,
  parameter logic [31:0] ID    = 32'h980055AA,
  localparam int         POS_W = $clog2(OUT_W) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [4:0]       wr_data,
  input logic             sclk_prev,
  input logic             mode_prev,
  input logic [1:0]       st,
  input logic [POS_W-1:0] pos,
  input logic [OUT_W-1:0] shreg,
  input logic             rd_bit
);

  logic fall_w, no_exec;
  assign fall_w  = wr_en & sclk_prev & ~wr_data[1];
  assign no_exec = ~(mode_prev & ~wr_data[4]);

  // R3: local reset without an edge returns to idle at position 0
  a_r3_local_reset: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[2] && !fall_w) |=> (st == 2'd0 && pos == '0));

  // R4: start on a falling edge from idle loads the identifier
  a_r4_load_id: assert property (@(posedge clk) disable iff (rst)
    (fall_w && !wr_data[2] && st == 2'd0 && wr_data[3] && no_exec)
    |=> (st == 2'd1 && shreg == ID[OUT_W-1:0] && pos == '0));

  // R5: each falling edge in shift advances the position
  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    (fall_w && !wr_data[2] && st == 2'd2 && no_exec && pos != '1)
    |=> (pos == $past(pos) + 1'b1));

  // R6: positions past the last bit read as zero
  a_r6_beyond_zero: assert property (@(posedge clk) disable iff (rst)
    (pos >= POS_W'(OUT_W)) |=> !rd_bit);

  // R11: no strobe, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(st) && $stable(pos) && $stable(shreg)));

endmodule

bind serial_id_responder srid_checker #(.OUT_W(OUT_W), .ID(ID)) u_srid_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data[4:0]),
  .sclk_prev(sclk_prev), .mode_prev(mode_prev), .st(st), .pos(pos),
  .shreg(shreg), .rd_bit(rd_bit)
);

// File: tb/tb_serial_id_responder.sv
module tb_serial_id_responder;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_REF = 32'h980055AA;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic       rd_bit;

  int checks = 0;
  int errors = 0;

  // model state
  int         m_st, m_pos;
  logic [31:0] m_out;
  logic       m_clk, m_mode;
  logic [7:0] m_cmd, m_last;
  logic [5:0] m_idx;

  serial_id_responder dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_bit(rd_bit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_ref(input int a);
    int t;
    t = ((a * 29) >> 1) & 255;
    return 8'((t + 'hA5) & 255);
  endfunction

  function automatic int slot_ref(input logic [7:0] c);
    case (c)
      8'h55: return 0; 8'hAA: return 1; 8'h54: return 2; 8'hA8: return 3;
      8'h50: return 4; 8'hA0: return 5; 8'h40: return 6; 8'h80: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic exp_bit();
    return (m_pos < 32) ? m_out[31 - m_pos] : 1'b0;
  endfunction

  task automatic model_reset();
    m_st = 0; m_pos = 0; m_out = '0; m_clk = 0; m_mode = 0;
    m_cmd = '0; m_last = '0; m_idx = '0;
  endtask

  task automatic model_write(input logic [4:0] w);
    logic d, c, lr, s, md, fl, rs;
    d = w[0]; c = w[1]; lr = w[2]; s = w[3]; md = w[4];
    fl = m_clk & ~c;
    rs = ~m_clk & c;
    if (lr) begin m_st = 0; m_pos = 0; end
    if (fl) begin
      if (m_st == 0 && s) m_st = 1;
      else if (m_st == 1 && !s) m_st = 2;
      if (m_st == 1) begin m_out = ID_REF; m_pos = 0; end
      else if (m_st == 2 && m_pos < 63) m_pos++;
      if (m_mode && !md && m_cmd != m_last) begin
        if (m_cmd[7] && m_cmd[0]) begin
          m_idx = m_cmd[6:1]; m_out = '0; m_pos = 0;
        end else if (slot_ref(m_cmd) >= 0) begin
          m_out = {rom_ref(int'(m_idx) * 8 + slot_ref(m_cmd)), 24'h0};
          m_pos = 0; m_st = 2;
        end
        m_last = m_cmd;
      end
      m_mode = md;
    end
    if (rs && md) begin
      m_cmd = {m_cmd[6:0], d};
      m_mode = 1'b1;
    end
    m_clk = c;
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_bit=%0b expected %0b", tag, act, exp);
    end
  endtask

  // write at a falling edge, sample two rising edges later
  task automatic wr(input logic [4:0] w, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(w);
    @(negedge clk);
    check(tag, rd_bit, exp_bit());
  endtask

  task automatic pulse(input logic [4:0] hi, input string tag);
    wr(hi | 5'b00010, tag);
    wr(hi & 5'b11101, tag);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) begin
      wr({1'b1, 2'b00, 1'b0, c[i]}, "R7 cmd shift");
      wr({1'b1, 2'b00, 1'b1, c[i]}, "R7 cmd shift");
    end
    wr(5'b00000, "R8 execute");
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] got;
    logic [7:0]  gb;
    logic [4:0]  w;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rd_bit", rd_bit, 1'b0);

    // R4/R5: identifier readout, MSB first
    wr(5'b01010, "R4 start high");
    wr(5'b01000, "R4 load id");
    got = '0;
    got[31] = rd_bit;
    for (int i = 30; i >= 0; i--) begin
      pulse(5'b00000, "R5 shift");
      got[i] = rd_bit;
    end
    checks++;
    if (got !== ID_REF) begin
      errors++;
      $display("FAIL R5 id readout: got %h expected %h", got, ID_REF);
    end
    pulse(5'b00000, "R6 past bit 0");
    check("R6 beyond 31 reads 0", rd_bit, 1'b0);

    // R11: noise without strobe
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      wr_data = 5'($urandom);
      @(negedge clk);
      check("R11 no strobe", rd_bit, exp_bit());
    end

    // R9/R10: select block 2, fetch byte 0
    send_cmd(8'h85);
    check("R9 index clears output", rd_bit, 1'b0);
    send_cmd(8'h55);
    gb = '0;
    gb[7] = rd_bit;
    for (int i = 6; i >= 0; i--) begin
      pulse(5'b00000, "R10 byte shift");
      gb[i] = rd_bit;
    end
    checks++;
    if (gb !== rom_ref(16)) begin
      errors++;
      $display("FAIL R10 byte readout: got %h expected %h", gb, rom_ref(16));
    end
    // R8: repeat the same command: no reload, bit should stay 0
    send_cmd(8'h55);
    check("R8 repeat ignored", rd_bit, 1'b0);

    // R3: local reset mid-shift
    wr(5'b00100, "R3 local reset");
    check("R3 position cleared reads top bit", rd_bit, m_out[31]);

    // R2/R8: command lands on rising edges only, mode-gated
    send_cmd(8'h87);
    send_cmd(8'hA0);
    send_cmd(8'h81);
    send_cmd(8'h40);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      w = 5'($urandom);
      if (($urandom % 8) != 0) w[2] = 1'b0;
      wr(w, "R2 R4 R5 R7 R8 R9 R10 random");
    end

    // R1: synchronous reset clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1 reset after run", rd_bit, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule